// File: doc/BRIEF.md
# Auxiliary Packet Link Controller

This block moves short auxiliary packets between software and a serial link whose slots are shared with real-time frames, and those frames always take precedence. Software writes up to fifteen 32-bit words into a transmit buffer. It then writes a length in bytes and sets a start bit, and it polls that bit until the packet has left. On the link side the controller emits a start marker, the data words in order and an end marker, one symbol per cycle. It steps aside in any cycle where the real-time request is high or the link is not ready.

In the other direction, a framed packet arriving on the link is stored in a receive buffer. A present flag and a byte length are then raised. Software reads the words and writes one to the present flag to release the buffer. A packet that arrives while the buffer is still held is discarded, and the discard is recorded in a sticky overflow flag. The link is modelled at the symbol level, so the transmit side can be looped back to the receive side.

Top module: `aux_link_ctrl`

## Requirements
- R1: After reset, the busy bit, the present flag and the overflow flag read 0, and `tx_kind` is idle (0).
- R2: Word addresses 0..15 write the transmit buffer, 256..270 read the receive buffer, and 512..516 are the control words. 512 is the length in bytes. Bit 0 of 513 is start/busy. Bit 0 of 514 is present, and writing 1 clears it. 515 is the received length in bytes. Bit 0 of 516 is overflow, and writing 1 clears it.
- R3: The word count is the byte length divided by four, rounded down, and capped at 15 words. The received length reads as that count times four.
- R4: Writing 1 to start sets busy on the next cycle. Busy stays 1 until the end marker has been emitted, then reads 0. Symbol kinds are 0 idle, 1 start, 2 data and 3 end.
- R5: While `link_ready` is low, `tx_kind` stays idle, and a pending packet waits for the link.
- R6: In any cycle with `rt_req` high, `tx_kind` is idle. The packet resumes afterwards with no word lost or repeated.
- R7: A start written while busy is ignored. Neither the packet in flight nor its length changes, and no second packet follows.
- R8: After an end marker, the present flag reads 1. The receive length equals four times the number of data words, and the buffer holds the words in arrival order.
- R9: Writing 1 to bit 0 of word 514 clears the present flag. Writing 0 leaves it set.
- R10: A packet that arrives while present is set leaves the buffer and the length unchanged and sets the overflow flag. The flag stays set until 1 is written to bit 0 of word 516.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| link_ready | input | 1 | Link initialised and usable |
| rt_req | input | 1 | Real-time frame owns the current slot |
| tx_kind | output | 2 | Transmitted symbol kind |
| tx_data | output | 32 | Transmitted data word |
| rx_kind | input | 2 | Received symbol kind |
| rx_data | input | 32 | Received data word |

## Verification
The assertions assume that received symbols are well formed. A data or end symbol counts only after a start marker, and software writes 1 to acknowledge only after it has seen the present flag. The bench meets these assumptions by looping `tx_kind`/`tx_data` straight back into the receive port, so every received symbol comes from the controller's own transmitter. `rt_req` toggles at random on falling edges and is never tied to the packet state, so pauses land on start, data and end symbols alike.

// File: rtl/aux_link_pkg.sv
package aux_link_pkg;
  localparam int MAX_WORDS = 15;
  localparam int WCNT_W    = 5;

  typedef enum logic [1:0] {
    SYM_IDLE = 2'd0,
    SYM_SOP  = 2'd1,
    SYM_DATA = 2'd2,
    SYM_EOP  = 2'd3
  } sym_e;

  // byte length -> word count, rounded down and capped
  function automatic logic [WCNT_W-1:0] bytes_to_words(input logic [31:0] nbytes);
    logic [31:0] w;
    w = nbytes >> 2;
    if (w > 32'(MAX_WORDS)) w = 32'(MAX_WORDS);
    return w[WCNT_W-1:0];
  endfunction

  function automatic logic [31:0] words_to_bytes(input logic [WCNT_W-1:0] n);
    return 32'(n) << 2;
  endfunction
endpackage

// File: rtl/aux_tx_engine.sv
module aux_tx_engine
  import aux_link_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_we,
  input  logic [IDX_W-1:0]  buf_waddr,
  input  logic [DW-1:0]     buf_wdata,
  input  logic              start,
  input  logic [WCNT_W-1:0] len_words,
  input  logic              link_ready,
  input  logic              rt_req,
  output logic              busy,
  output logic [1:0]        sym_kind,
  output logic [DW-1:0]     sym_data
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DW-1:0]     mem [DEPTH];
  sym_e              phase;
  logic [WCNT_W-1:0] idx;
  logic [WCNT_W-1:0] nwords;

  logic slot_ok, emit, start_acc, last_word;
  assign slot_ok   = link_ready && !rt_req;
  assign emit      = busy && slot_ok;
  assign start_acc = start && !busy;
  assign last_word = (WCNT_W'(idx + 1'b1) == nwords);

  always_ff @(posedge clk) begin
    if (buf_we) mem[buf_waddr] <= buf_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= SYM_SOP;
      idx    <= '0;
      nwords <= '0;
    end else if (start_acc) begin
      busy   <= 1'b1;
      phase  <= SYM_SOP;
      idx    <= '0;
      nwords <= len_words;
    end else if (emit) begin
      case (phase)
        SYM_SOP:  phase <= (nwords == '0) ? SYM_EOP : SYM_DATA;
        SYM_DATA: begin
          idx <= idx + 1'b1;
          if (last_word) phase <= SYM_EOP;
        end
        SYM_EOP:  busy <= 1'b0;
        default:  phase <= SYM_SOP;
      endcase
    end
  end

  assign sym_kind = emit ? phase : SYM_IDLE;
  assign sym_data = (emit && phase == SYM_DATA) ? mem[idx[IDX_W-1:0]] : '0;

  AST_QUIET_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ready |-> sym_kind == SYM_IDLE); // R5
  AST_FREEZE_ON_RT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rt_req |=> $stable(idx) && $stable(phase)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(nwords)); // R7
  AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(phase) == SYM_EOP && $past(emit)); // R4
endmodule

// File: rtl/aux_rx_engine.sv
module aux_rx_engine
  import aux_link_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sym_kind,
  input  logic [DW-1:0]    sym_data,
  input  logic             ack,
  input  logic             ovf_clr,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata,
  output logic             present,
  output logic [31:0]      len_bytes,
  output logic             overflow
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DW-1:0]     mem [DEPTH];
  logic              in_pkt, drop;
  logic [WCNT_W-1:0] cnt, len_words;

  logic got_sop, got_data, got_eop, wr_word, pkt_done, pkt_drop;
  assign got_sop  = sym_kind == SYM_SOP;
  assign got_data = sym_kind == SYM_DATA && in_pkt;
  assign got_eop  = sym_kind == SYM_EOP && in_pkt;
  assign wr_word  = got_data && !drop && cnt < WCNT_W'(MAX_WORDS);
  assign pkt_done = got_eop && !drop;
  assign pkt_drop = got_eop && drop;

  always_ff @(posedge clk) begin
    if (wr_word) mem[cnt[IDX_W-1:0]] <= sym_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      drop   <= 1'b0;
      cnt    <= '0;
    end else if (got_sop) begin
      in_pkt <= 1'b1;
      drop   <= present;
      cnt    <= '0;
    end else if (got_data) begin
      if (cnt < WCNT_W'(MAX_WORDS)) cnt <= cnt + 1'b1;
    end else if (got_eop) begin
      in_pkt <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present   <= 1'b0;
      len_words <= '0;
      overflow  <= 1'b0;
    end else begin
      if (pkt_done) begin
        present   <= 1'b1;
        len_words <= cnt;
      end else if (ack) begin
        present <= 1'b0;
      end
      if (pkt_drop)     overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;
    end
  end

  assign rdata     = mem[raddr];
  assign len_bytes = words_to_bytes(len_words);

  AST_PRESENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    present && !ack |=> present); // R9
  AST_NO_WRITE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    present |-> !wr_word); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow); // R10
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    present |-> len_words <= WCNT_W'(MAX_WORDS)); // R3
endmodule

// File: rtl/aux_link_ctrl.sv
module aux_link_ctrl
  import aux_link_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DW       = 32,
  parameter int IDX_W    = 4,
  parameter int RX_BASE  = 256,
  parameter int CSR_BASE = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              link_ready,
  input  logic              rt_req,
  output logic [1:0]        tx_kind,
  output logic [DW-1:0]     tx_data,
  input  logic [1:0]        rx_kind,
  input  logic [DW-1:0]     rx_data
);
  localparam int DEPTH = 2 ** IDX_W;
  localparam logic [ADDR_W-1:0] A_RXB   = ADDR_W'(RX_BASE);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(CSR_BASE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CSR_BASE + 1);
  localparam logic [ADDR_W-1:0] A_PRES  = ADDR_W'(CSR_BASE + 2);
  localparam logic [ADDR_W-1:0] A_RXLEN = ADDR_W'(CSR_BASE + 3);
  localparam logic [ADDR_W-1:0] A_OVF   = ADDR_W'(CSR_BASE + 4);

  logic          tx_sel, rx_sel, start_wr, ack_wr, ovf_wr, busy, present, overflow;
  logic [31:0]   tx_len_q, rx_len;
  logic [DW-1:0] rx_rd;
  logic [ADDR_W-1:0] rx_off;

  assign tx_sel   = bus_addr < ADDR_W'(DEPTH);
  assign rx_off   = bus_addr - A_RXB;
  assign rx_sel   = bus_addr >= A_RXB && rx_off < ADDR_W'(DEPTH);
  assign start_wr = bus_we && bus_addr == A_CTRL && bus_wdata[0];
  assign ack_wr   = bus_we && bus_addr == A_PRES && bus_wdata[0];
  assign ovf_wr   = bus_we && bus_addr == A_OVF  && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                          tx_len_q <= '0;
    else if (bus_we && bus_addr == A_LEN) tx_len_q <= 32'(bus_wdata);
  end

  aux_tx_engine #(.DW(DW), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .buf_we(bus_we && tx_sel), .buf_waddr(bus_addr[IDX_W-1:0]), .buf_wdata(bus_wdata),
    .start(start_wr), .len_words(bytes_to_words(tx_len_q)),
    .link_ready(link_ready), .rt_req(rt_req),
    .busy(busy), .sym_kind(tx_kind), .sym_data(tx_data)
  );

  aux_rx_engine #(.DW(DW), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sym_kind(rx_kind), .sym_data(rx_data),
    .ack(ack_wr), .ovf_clr(ovf_wr),
    .raddr(rx_off[IDX_W-1:0]), .rdata(rx_rd),
    .present(present), .len_bytes(rx_len), .overflow(overflow)
  );

  always_comb begin
    bus_rdata = '0;
    if (rx_sel) bus_rdata = rx_rd;
    else begin
      case (bus_addr)
        A_LEN:   bus_rdata = DW'(tx_len_q);
        A_CTRL:  bus_rdata = DW'(busy);
        A_PRES:  bus_rdata = DW'(present);
        A_RXLEN: bus_rdata = DW'(rx_len);
        A_OVF:   bus_rdata = DW'(overflow);
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !busy |=> busy); // R4
endmodule

// File: tb/aux_link_ctrl_tb.sv
module aux_link_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        link_ready = 1'b0;
  logic        rt_req = 1'b0;
  logic        rt_en = 1'b0;
  logic [1:0]  tx_kind;
  logic [31:0] tx_data;

  int checks = 0, errors = 0, rt_viol = 0, nr_viol = 0;
  logic [31:0] pkt [16];

  always #2.5 clk = ~clk;

  aux_link_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_ready(link_ready),
    .rt_req(rt_req), .tx_kind(tx_kind), .tx_data(tx_data),
    .rx_kind(tx_kind), .rx_data(tx_data)
  );

  function automatic int exp_words(input int nbytes);
    int w = nbytes / 4;
    return (w > 15) ? 15 : w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a);
    #1 d = bus_rdata;
  endtask

  task automatic load_and_start(input int nw, input int nbytes);
    for (int i = 0; i < nw; i++) wr(i, pkt[i]);
    wr(512, 32'(nbytes));
    wr(513, 32'd1);
  endtask

  task automatic wait_flag(input int a, input logic val, input string req);
    logic [31:0] d;
    int n = 0;
    rd(a, d);
    while (d[0] != val && n < 3000) begin rd(a, d); n++; end
    check(d[0] == val, req, d, 32'(val));
  endtask

  task automatic expect_packet(input int nw, input string req);
    logic [31:0] d;
    rd(515, d);
    check(d == 32'(nw * 4), req, d, 32'(nw * 4));
    for (int i = 0; i < nw; i++) begin
      rd(256 + i, d);
      check(d == pkt[i], req, d, pkt[i]);
    end
  endtask

  // random real-time slot requests, changed only on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (rt_en && ($urandom % 4 == 0)) rt_req = ~rt_req;
      else if (!rt_en) rt_req = 1'b0;
    end
  end

  // R6 / R5 link monitors
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rt_req && tx_kind != 2'd0) rt_viol++;
      if (rst_n && !link_ready && tx_kind != 2'd0) nr_viol++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(513, d); check(d == 0, "R1 busy", d, 0);
    rd(514, d); check(d == 0, "R1 present", d, 0);
    rd(516, d); check(d == 0, "R1 overflow", d, 0);
    check(tx_kind == 2'd0, "R1 tx_kind", 32'(tx_kind), 0);

    // R5: link not ready holds the packet
    for (int i = 0; i < 3; i++) pkt[i] = 32'hA5A5_0000 + 32'(i);
    load_and_start(3, 12);
    repeat (20) @(negedge clk);
    rd(513, d); check(d == 1, "R4 busy while pending", d, 1);
    check(nr_viol == 0, "R5 no symbols before ready", nr_viol, 0);
    link_ready = 1'b1;
    wait_flag(513, 1'b0, "R4 busy clears");
    wait_flag(514, 1'b1, "R8 present");
    expect_packet(3, "R5 held packet");
    wr(514, 32'd1);

    // R6/R8 random packets with real-time interruptions
    rt_en = 1'b1;
    for (int p = 0; p < 8; p++) begin
      int nw = 1 + int'($urandom % 15);
      for (int i = 0; i < nw; i++) pkt[i] = $urandom;
      load_and_start(nw, nw * 4);
      wait_flag(513, 1'b0, "R4 done");
      wait_flag(514, 1'b1, "R8 present");
      expect_packet(nw, "R6 R8 words");
      wr(514, 32'd1);
      rd(514, d); check(d == 0, "R9 ack clears", d, 0);
    end

    // R3 clamp and rounding
    for (int i = 0; i < 15; i++) pkt[i] = $urandom;
    load_and_start(15, 100);
    wait_flag(514, 1'b1, "R3 present");
    expect_packet(exp_words(100), "R3 clamp");
    wr(514, 32'd1);
    load_and_start(6, 22);
    wait_flag(514, 1'b1, "R3 present");
    expect_packet(exp_words(22), "R3 round down");
    wr(514, 32'd1);

    // R7 start while busy ignored
    for (int i = 0; i < 10; i++) pkt[i] = 32'hC0DE_0000 + 32'(i);
    load_and_start(10, 40);
    wr(512, 32'd8);
    wr(513, 32'd1);
    wait_flag(513, 1'b0, "R7 done");
    wait_flag(514, 1'b1, "R7 present");
    expect_packet(10, "R7 original length");
    wr(514, 32'd1);
    repeat (60) @(negedge clk);
    rd(514, d); check(d == 0, "R7 no second packet", d, 0);

    // R9 write zero has no effect
    pkt[0] = 32'h1234_5678; pkt[1] = 32'h9ABC_DEF0;
    load_and_start(2, 8);
    wait_flag(514, 1'b1, "R9 present");
    wr(514, 32'd0);
    rd(514, d); check(d == 1, "R9 zero write keeps present", d, 1);

    // R10 second packet dropped while held
    for (int i = 0; i < 4; i++) pkt[i + 4] = 32'hFFFF_0000 + 32'(i);
    for (int i = 0; i < 4; i++) wr(i, pkt[i + 4]);
    wr(512, 32'd16);
    wr(513, 32'd1);
    wait_flag(513, 1'b0, "R10 sent");
    wait_flag(516, 1'b1, "R10 overflow");
    rd(514, d); check(d == 1, "R10 present kept", d, 1);
    expect_packet(2, "R10 buffer intact");
    wr(516, 32'd0);
    rd(516, d); check(d == 1, "R10 overflow sticky", d, 1);
    wr(516, 32'd1);
    rd(516, d); check(d == 0, "R10 overflow clear", d, 0);
    wr(514, 32'd1);

    // R2 control word readback
    rd(512, d); check(d == 16, "R2 length readback", d, 16);

    rt_en = 1'b0;
    check(rt_viol == 0, "R6 idle during rt", rt_viol, 0);
    check(nr_viol == 0, "R5 idle while not ready", nr_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule